// File: doc/BRIEF.md
# N-plex Voted Fitness Evaluator

This block grades a group of redundant copies of one small combinational circuit against a truth table. It grades each copy on its own and also grades the bitwise majority of the copies, all in the same pass. After a start pulse it steps through every row of the table, one row per cycle. For each row it drives the row's 6-bit stimulus to all copies and captures their 6-bit responses. It forms a per-bit majority over the copies that are in play. Then it adds up the matching output bits for each copy and for the voted word. A perfect score is the row count times the output width: 60 for the default ten rows.

The table itself lives outside the block. The block puts out a row index and reads back that row's stimulus and expected response in the same cycle. The vote spans either three or five copies, chosen when the pass starts. When a pass finishes, the block pulses a done flag and shows the scores. It also shows the highest copy score and which copy earned it. A repair or search engine can use these numbers to decide whether a partly repaired set of copies already gives correct system behaviour.

Top module: `nplex_fitness_scorer`

## Requirements
- R1: After reset, `done` and `busy` are 0, and every score output (`rep_fit`, `vote_fit`, `best_fit`) reads 0.
- R2: A start pulse is accepted when `busy` is 0. In the cycle after the accepting edge, `tv_idx` shows 0, and it then advances by one per cycle up to NUM_VEC-1. `rep_in` shows the stimulus `tv_in` read at index k during the cycle after `tv_idx` showed k.
- R3: The response scored for row k is the value on `rep_out` during the cycle in which `rep_in` shows row k's stimulus. Copy slot i occupies bits `rep_out[6*i+5:6*i]`, for slots 0 to 4.
- R4: At done, `rep_fit[6*i+5:6*i]` is the number of bits of slot i's response that equal `tv_exp`, summed over all rows. The maximum is 60.
- R5: Each bit of the voted word is 1 when at least 2 of slots 0 to 2 drive it high (three-copy mode) or at least 3 of slots 0 to 4 drive it high (five-copy mode). `vote_fit` counts the voted word's matching bits over all rows, in the same way as R4.
- R6: `five_mode`, sampled with the accepted start, selects five-copy mode when 1 and three-copy mode when 0. In three-copy mode, slots 3 and 4 do not affect the vote or the best-copy result, and their scores read 0.
- R7: All scores clear when a start is accepted. `done` goes high for exactly one cycle, NUM_VEC+2 clock edges after the accepting edge (the 12th edge after it for ten rows). The scores are final in that cycle and stay unchanged until the next accepted start.
- R8: `best_fit` equals the highest score among the active slots. `best_idx` gives that slot's number, and the lowest number wins a tie.
- R9: A start pulse while `busy` is 1 has no effect: the index sequence, the mode, the done timing and the scores all stay as they would be without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scoring pass |
| five_mode | input | 1 | 1 = five-copy vote, 0 = three-copy vote; sampled at start |
| tv_idx | output | 4 | Row index of the external truth table |
| tv_in | input | 6 | Stimulus of the row at `tv_idx` |
| tv_exp | input | 6 | Expected response of the row at `tv_idx` |
| rep_in | output | 6 | Stimulus driven to all copies |
| rep_out | input | 30 | Responses of copy slots 0 to 4, 6 bits each |
| rep_fit | output | 30 | Scores of slots 0 to 4, 6 bits each |
| vote_fit | output | 6 | Score of the majority-voted word |
| best_fit | output | 6 | Highest active copy score |
| best_idx | output | 3 | Slot number of the highest active copy score |
| busy | output | 1 | A pass is in flight |
| done | output | 1 | One-cycle pulse when the scores are final |

## Verification
The hardest case to reach is a voted word whose score differs from what any single copy shows. Getting there needs several copies to be wrong on the same bit for the same stimulus while the rest stay right. The bench builds this from per-copy fault masks indexed by the stimulus value. Directed masks make two of three copies agree on a wrong bit in three-copy mode. In five-copy mode, directed masks push the dead slots into the vote. Seeded random masks cover overlapping faults more broadly. A start pulse issued mid-pass with the opposite mode checks that the running pass keeps its mode and timing.

// File: rtl/nfs_pkg.sv
package nfs_pkg;

    localparam int NFS_IN_W    = 6;
    localparam int NFS_OUT_W   = 6;
    localparam int NFS_NUM_VEC = 10;
    localparam int NFS_MAX_REP = 5;

    typedef enum logic {
        MODE_THREE = 1'b0,
        MODE_FIVE  = 1'b1
    } vote_mode_e;

    typedef struct packed {
        logic valid;
        logic last;
    } stage_t;

    function automatic int active_lanes(vote_mode_e m);
        return (m == MODE_FIVE) ? 5 : 3;
    endfunction

endpackage

// File: rtl/nfs_sequencer.sv
module nfs_sequencer
    import nfs_pkg::*;
#(
    parameter int NUM_VEC = NFS_NUM_VEC,
    localparam int IDX_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             five_mode,
    output logic [IDX_W-1:0] idx,
    output logic             issue,
    output logic             accept,
    output vote_mode_e       mode,
    output stage_t           st1,
    output stage_t           st2,
    output logic             busy,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_VEC - 1);

    logic   run_q;
    logic   done_q;

    assign busy   = run_q | st1.valid | st2.valid;
    assign accept = start & ~busy;
    assign issue  = run_q;
    assign done   = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            idx    <= '0;
            mode   <= MODE_THREE;
            st1    <= '0;
            st2    <= '0;
            done_q <= 1'b0;
        end else begin
            if (accept) begin
                run_q <= 1'b1;
                idx   <= '0;
                mode  <= five_mode ? MODE_FIVE : MODE_THREE;
            end else if (run_q) begin
                if (idx == LAST) begin
                    run_q <= 1'b0;
                    idx   <= '0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
            st1.valid <= run_q;
            st1.last  <= run_q && (idx == LAST);
            st2       <= st1;
            done_q    <= st2.valid && st2.last;
        end
    end

    p_idx_range_r2: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (idx <= LAST));

    p_idx_step_r2: assert property (@(posedge clk) disable iff (rst)
        (run_q && idx != LAST && !accept) |=> (run_q && idx == $past(idx) + 1'b1));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(mode));

endmodule

// File: rtl/nfs_majority.sv
module nfs_majority
    import nfs_pkg::*;
#(
    parameter int OUT_W   = NFS_OUT_W,
    parameter int MAX_REP = NFS_MAX_REP,
    localparam int CNT_W  = $clog2(MAX_REP + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [MAX_REP*OUT_W-1:0] lanes,
    input  vote_mode_e               mode,
    output logic [OUT_W-1:0]         vote
);
    logic [CNT_W-1:0] thresh;

    always_comb begin
        thresh = CNT_W'(active_lanes(mode) / 2 + 1);
    end

    for (genvar b = 0; b < OUT_W; b++) begin : g_bit
        logic [CNT_W-1:0] ones;
        always_comb begin
            ones = '0;
            for (int l = 0; l < MAX_REP; l++) begin
                if (l < active_lanes(mode) && lanes[l*OUT_W + b])
                    ones = ones + 1'b1;
            end
            vote[b] = (ones >= thresh);
        end
    end

    p_vote_unanimous_r5: assert property (@(posedge clk) disable iff (rst)
        (lanes[OUT_W-1:0] == lanes[2*OUT_W-1:OUT_W] &&
         lanes[OUT_W-1:0] == lanes[3*OUT_W-1:2*OUT_W] && mode == MODE_THREE)
        |-> (vote == lanes[OUT_W-1:0]));

endmodule

// File: rtl/nfs_scorer.sv
module nfs_scorer #(
    parameter int OUT_W   = 6,
    parameter int NUM_VEC = 10,
    localparam int FIT_W  = $clog2(NUM_VEC * OUT_W + 1),
    localparam int HIT_W  = $clog2(OUT_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             acc_en,
    input  logic             lane_en,
    input  logic [OUT_W-1:0] obs,
    input  logic [OUT_W-1:0] expv,
    output logic [FIT_W-1:0] fit
);
    logic [HIT_W-1:0] hits;

    always_comb begin
        hits = '0;
        for (int b = 0; b < OUT_W; b++)
            if (obs[b] == expv[b]) hits = hits + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clear)
            fit <= '0;
        else if (acc_en && lane_en)
            fit <= fit + FIT_W'(hits);
    end

    p_fit_cap_r4: assert property (@(posedge clk) disable iff (rst)
        fit <= FIT_W'(NUM_VEC * OUT_W));

    p_idle_lane_r6: assert property (@(posedge clk) disable iff (rst)
        (!lane_en && !clear) |=> $stable(fit));

endmodule

// File: rtl/nfs_best_pick.sv
module nfs_best_pick
    import nfs_pkg::*;
#(
    parameter int MAX_REP = NFS_MAX_REP,
    parameter int FIT_W   = 6,
    localparam int SEL_W  = $clog2(MAX_REP)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [MAX_REP*FIT_W-1:0] fits,
    input  vote_mode_e               mode,
    output logic [FIT_W-1:0]         best_fit,
    output logic [SEL_W-1:0]         best_idx
);
    always_comb begin
        best_fit = fits[FIT_W-1:0];
        best_idx = '0;
        for (int l = 1; l < MAX_REP; l++) begin
            if (l < active_lanes(mode) && fits[l*FIT_W +: FIT_W] > best_fit) begin
                best_fit = fits[l*FIT_W +: FIT_W];
                best_idx = SEL_W'(l);
            end
        end
    end

    p_best_covers_r8: assert property (@(posedge clk) disable iff (rst)
        (best_fit >= fits[FIT_W-1:0]) &&
        (best_fit >= fits[2*FIT_W-1:FIT_W]) &&
        (best_fit >= fits[3*FIT_W-1:2*FIT_W]));

    p_best_lowest_r8: assert property (@(posedge clk) disable iff (rst)
        (fits[FIT_W-1:0] == best_fit) |-> (best_idx == '0));

endmodule

// File: rtl/nplex_fitness_scorer.sv
module nplex_fitness_scorer
    import nfs_pkg::*;
#(
    parameter int IN_W    = NFS_IN_W,
    parameter int OUT_W   = NFS_OUT_W,
    parameter int NUM_VEC = NFS_NUM_VEC,
    parameter int MAX_REP = NFS_MAX_REP,
    localparam int IDX_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
    localparam int FIT_W  = $clog2(NUM_VEC * OUT_W + 1),
    localparam int SEL_W  = $clog2(MAX_REP)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic                     five_mode,
    output logic [IDX_W-1:0]         tv_idx,
    input  logic [IN_W-1:0]          tv_in,
    input  logic [OUT_W-1:0]         tv_exp,
    output logic [IN_W-1:0]          rep_in,
    input  logic [MAX_REP*OUT_W-1:0] rep_out,
    output logic [MAX_REP*FIT_W-1:0] rep_fit,
    output logic [FIT_W-1:0]         vote_fit,
    output logic [FIT_W-1:0]         best_fit,
    output logic [SEL_W-1:0]         best_idx,
    output logic                     busy,
    output logic                     done
);
    logic                     issue;
    logic                     accept;
    vote_mode_e               mode;
    stage_t                   st1;
    stage_t                   st2;
    logic [OUT_W-1:0]         exp_s1;
    logic [OUT_W-1:0]         exp_s2;
    logic [MAX_REP*OUT_W-1:0] samp_q;
    logic [OUT_W-1:0]         vote;

    nfs_sequencer #(.NUM_VEC(NUM_VEC)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .five_mode (five_mode),
        .idx       (tv_idx),
        .issue     (issue),
        .accept    (accept),
        .mode      (mode),
        .st1       (st1),
        .st2       (st2),
        .busy      (busy),
        .done      (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rep_in <= '0;
            exp_s1 <= '0;
            samp_q <= '0;
            exp_s2 <= '0;
        end else begin
            if (issue) begin
                rep_in <= tv_in;
                exp_s1 <= tv_exp;
            end
            if (st1.valid) begin
                samp_q <= rep_out;
                exp_s2 <= exp_s1;
            end
        end
    end

    nfs_majority #(.OUT_W(OUT_W), .MAX_REP(MAX_REP)) u_vote (
        .clk   (clk),
        .rst   (rst),
        .lanes (samp_q),
        .mode  (mode),
        .vote  (vote)
    );

    for (genvar l = 0; l < MAX_REP; l++) begin : g_lane
        nfs_scorer #(.OUT_W(OUT_W), .NUM_VEC(NUM_VEC)) u_score (
            .clk     (clk),
            .rst     (rst),
            .clear   (accept),
            .acc_en  (st2.valid),
            .lane_en (l < active_lanes(mode)),
            .obs     (samp_q[l*OUT_W +: OUT_W]),
            .expv    (exp_s2),
            .fit     (rep_fit[l*FIT_W +: FIT_W])
        );
    end

    nfs_scorer #(.OUT_W(OUT_W), .NUM_VEC(NUM_VEC)) u_vote_score (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .acc_en  (st2.valid),
        .lane_en (1'b1),
        .obs     (vote),
        .expv    (exp_s2),
        .fit     (vote_fit)
    );

    nfs_best_pick #(.MAX_REP(MAX_REP), .FIT_W(FIT_W)) u_best (
        .clk      (clk),
        .rst      (rst),
        .fits     (rep_fit),
        .mode     (mode),
        .best_fit (best_fit),
        .best_idx (best_idx)
    );

    p_three_mode_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (done && mode == MODE_THREE) |-> (rep_fit[MAX_REP*FIT_W-1:3*FIT_W] == '0));

    p_clear_on_start_r7: assert property (@(posedge clk) disable iff (rst)
        accept |=> (vote_fit == '0));

endmodule

// File: tb/nplex_fitness_scorer_tb.sv
module nplex_fitness_scorer_tb;

    localparam int NV = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        five_mode;
    logic [3:0]  tv_idx;
    logic [5:0]  tv_in;
    logic [5:0]  tv_exp;
    logic [5:0]  rep_in;
    logic [29:0] rep_out;
    logic [29:0] rep_fit;
    logic [5:0]  vote_fit;
    logic [5:0]  best_fit;
    logic [2:0]  best_idx;
    logic        busy;
    logic        done;

    logic [5:0]  tin  [NV];
    logic [5:0]  flip [5][64];

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    nplex_fitness_scorer u_dut (
        .clk(clk), .rst(rst), .start(start), .five_mode(five_mode),
        .tv_idx(tv_idx), .tv_in(tv_in), .tv_exp(tv_exp),
        .rep_in(rep_in), .rep_out(rep_out), .rep_fit(rep_fit),
        .vote_fit(vote_fit), .best_fit(best_fit), .best_idx(best_idx),
        .busy(busy), .done(done)
    );

    function automatic logic [5:0] golden(logic [5:0] x);
        return 6'((x * 7 + 3) ^ (x >> 2));
    endfunction

    function automatic int pop6(logic [5:0] v);
        int c = 0;
        for (int b = 0; b < 6; b++) c += v[b];
        return c;
    endfunction

    // Truth table rows and copy models
    always_comb begin
        tv_in  = (tv_idx < NV) ? tin[tv_idx] : 6'd0;
        tv_exp = golden(tv_in);
        for (int i = 0; i < 5; i++)
            rep_out[6*i +: 6] = golden(rep_in) ^ flip[i][rep_in];
    end

    task automatic check(string req, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic clear_flips();
        for (int i = 0; i < 5; i++)
            for (int x = 0; x < 64; x++) flip[i][x] = 6'd0;
    endtask

    task automatic rand_rows();
        for (int r = 0; r < NV; r++) tin[r] = 6'($urandom);
    endtask

    task automatic rand_flips();
        for (int i = 0; i < 5; i++)
            for (int x = 0; x < 64; x++) begin
                logic [5:0] m = '0;
                for (int b = 0; b < 6; b++) m[b] = (($urandom % 6) == 0);
                flip[i][x] = m;
            end
    endtask

    // One pass: expected results computed from the requirements
    task automatic run_pass(bit five, bit poke_start);
        int act_n = five ? 5 : 3;
        int efit [5];
        int evote = 0;
        int ebest = 0;
        int ebidx = 0;
        for (int i = 0; i < 5; i++) efit[i] = 0;
        for (int r = 0; r < NV; r++) begin
            logic [5:0] x = tin[r];
            logic [5:0] e = golden(x);
            logic [5:0] v = '0;
            for (int b = 0; b < 6; b++) begin
                int ones = 0;
                for (int i = 0; i < act_n; i++) ones += (e[b] ^ flip[i][x][b]);
                v[b] = (ones >= act_n / 2 + 1);
            end
            for (int i = 0; i < act_n; i++) efit[i] += 6 - pop6(flip[i][x]);
            evote += 6 - pop6(v ^ e);
        end
        ebest = efit[0];
        for (int i = 1; i < act_n; i++)
            if (efit[i] > ebest) begin ebest = efit[i]; ebidx = i; end

        @(negedge clk);
        five_mode = five;
        start = 1'b1;
        for (int k = 1; k <= 14; k++) begin
            @(negedge clk);
            if (k == 1) start = 1'b0;
            if (poke_start && k == 5) begin start = 1'b1; five_mode = ~five; end
            if (poke_start && k == 6) start = 1'b0;
            if (k <= NV) check("R2 tv_idx", int'(tv_idx), k - 1);
            if (k >= 2 && k <= NV + 1) check("R2 rep_in", int'(rep_in), int'(tin[k-2]));
            if (k <= 12) check("R7 busy", int'(busy), 1);
            if (k == 12 || k == 14) check("R7 done low", int'(done), 0);
            if (k == 13) begin
                check("R7 done pulse", int'(done), 1);
                for (int i = 0; i < 5; i++)
                    check(i < act_n ? "R4 R3 rep_fit" : "R6 idle rep_fit",
                          int'(rep_fit[6*i +: 6]), efit[i]);
                check("R5 vote_fit", int'(vote_fit), evote);
                check("R8 best_fit", int'(best_fit), ebest);
                check("R8 best_idx", int'(best_idx), ebidx);
            end
        end
        check("R7 hold vote", int'(vote_fit), evote);
        check("R9 idle after pass", int'(busy), 0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; start = 1'b0; five_mode = 1'b0;
        clear_flips();
        for (int r = 0; r < NV; r++) tin[r] = 6'(r * 5 + 1);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 done", int'(done), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 vote_fit", int'(vote_fit), 0);
        check("R1 rep_fit", int'(rep_fit), 0);
        check("R1 best_fit", int'(best_fit), 0);
        rst = 1'b0;

        // R4/R8: clean copies score 60, tie goes to slot 0
        run_pass(1'b0, 1'b0);
        run_pass(1'b1, 1'b0);

        // R5/R6: two of three wrong on bit 0, dead slots fully corrupt
        for (int x = 0; x < 64; x++) begin
            flip[0][x] = 6'b000001; flip[1][x] = 6'b000001; flip[2][x] = 6'd0;
            flip[3][x] = 6'b111111; flip[4][x] = 6'b111111;
        end
        run_pass(1'b0, 1'b0);
        // R5 five-copy: corrupt slots now join the vote
        for (int x = 0; x < 64; x++) begin
            flip[0][x] = 6'b000100; flip[1][x] = 6'b000100;
        end
        run_pass(1'b1, 1'b0);

        // R9: start with opposite mode issued mid-pass
        rand_rows(); rand_flips();
        run_pass(1'b0, 1'b1);
        run_pass(1'b1, 1'b1);

        // Seeded random passes
        for (int t = 0; t < 10; t++) begin
            rand_rows(); rand_flips();
            run_pass(1'($urandom), 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule